// File: doc/BRIEF.md
# Receive-Only Byte Request Controller

This block runs the receive side of a serial master when the transmitter is off. Software writes a byte count. The block then keeps the shift engine clocking until that many bytes have come in. It gathers the incoming bytes into 32-bit words and hands each finished word to the receive FIFO. In this mode no transmit data is needed, and any word-width setting has no effect: every FIFO entry is a full 32-bit container.

When the request ends on a word that is not full, the block pushes that short word at once. The valid bytes sit at the low end of the word, and the first byte received is the most significant of them. A 3-bit valid-byte status tells software how many bytes of the last pushed word carry data. A 16-bit remaining-count output shows how many bytes are still owed. If the FIFO is full when a word completes, that word is dropped and a one-cycle overflow pulse is raised. The shift engine and the FIFO storage are outside this block.

Top module: `rxo_request_ctrl`

## Requirements
- R1: After reset the remaining count is 0, shift_run_o is low, no push or overflow pulse is active, and the valid-byte status is 0.
- R2: A request write with a nonzero count loads that count into the remaining count, and shift_run_o is high from the next cycle on. A request write with count 0 is ignored and leaves every output unchanged.
- R3: Each byte strobe taken while the remaining count is nonzero lowers the count by exactly one. A byte strobe while the count is 0 is ignored: there is no push and no change to any output.
- R4: Bytes are packed into 32-bit words with the first byte in bits 31:24. The word is pushed on the fourth byte, one cycle after that byte's strobe, and the valid-byte status then reads 4.
- R5: When the byte that brings the count to 0 completes a word of 1 to 3 bytes, that word is pushed at once. Its valid bytes are at the low end with the earliest byte most significant, its unused upper bytes are 0, and the valid-byte status equals the number of valid bytes.
- R6: shift_run_o goes low in the cycle after the last requested byte is taken.
- R7: If the FIFO level is at or above the FIFO depth (32 by default) in the cycle a word completes, no push happens, rx_ovf_o pulses for one cycle, and the word is discarded. The next word starts empty.
- R8: A nonzero request write while a request is active replaces the remaining count without adding to it. Bytes already gathered stay in the partial word and are completed by the new request.
- R9: If a request write and a byte strobe occur in the same cycle, the write wins and that byte is not taken.
- R10: The valid-byte status holds the value for the last pushed word until the next push. An overflow does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_wr_i | input | 1 | Request register write strobe |
| req_count_i | input | 16 | Byte count written with the strobe |
| byte_valid_i | input | 1 | Shift engine delivers a received byte |
| byte_data_i | input | 8 | Received byte |
| fifo_level_i | input | 6 | Current receive FIFO fill level |
| shift_run_o | output | 1 | Keep the shift engine clocking |
| remaining_o | output | 16 | Bytes still to be received |
| fifo_push_o | output | 1 | Write fifo_data_o into the receive FIFO |
| fifo_data_o | output | 32 | Packed receive word |
| rx_bv_o | output | 3 | Valid bytes in the last pushed word |
| rx_ovf_o | output | 1 | Completed word dropped because the FIFO was full |

## Verification
Every result is registered: the push, its data, the valid-byte status, the overflow pulse and the remaining count all change on the first rising edge after the cycle that holds the stimulus. shift_run_o follows the remaining count, so it changes on that same edge. The bench drives each stimulus on the falling edge and compares all outputs 1 ns after the next rising edge, which is exactly where a one-register result first appears. Directed cases then test the same-cycle write, the rewrite of an active request, and the ignored zero write and stray byte at that same sample point.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int BV_W       = $clog2(WORD_BYTES + 1);

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [BV_W-1:0]   nvalid;
  } rx_word_t;

  // append a byte at the low end, older bytes move toward the top
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] acc,
                                                 input logic [BYTE_W-1:0] b);
    return {acc[WORD_W-BYTE_W-1:0], b};
  endfunction

  // a word is closed when full or when the request runs out
  function automatic logic word_closes(input logic [BV_W-1:0] filled,
                                       input logic is_last);
    return (filled == BV_W'(WORD_BYTES)) || is_last;
  endfunction

  function automatic logic fifo_is_full(input int unsigned level,
                                        input int unsigned depth);
    return level >= depth;
  endfunction
endpackage

// File: rtl/rxo_req_counter.sv
module rxo_req_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_count_i,
  input  logic             byte_i,
  output logic [CNT_W-1:0] remaining_o,
  output logic             accept_o,
  output logic             last_o,
  output logic             run_o
);
  logic [CNT_W-1:0] rem_q;
  logic             load_en;

  assign load_en     = wr_i && (wr_count_i != '0);
  assign accept_o    = byte_i && !load_en && (rem_q != '0);
  assign last_o      = accept_o && (rem_q == CNT_W'(1));
  assign run_o       = (rem_q != '0);
  assign remaining_o = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rem_q <= '0;
    else if (load_en)  rem_q <= wr_count_i;
    else if (accept_o) rem_q <= rem_q - CNT_W'(1);
  end

  // R3
  rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_i && !wr_i && rem_q != '0) |=> (rem_q == $past(rem_q) - CNT_W'(1)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && rem_q == '0) |=> (rem_q == '0));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_count_i != '0) |=> (rem_q == $past(wr_count_i)));
endmodule

// File: rtl/rxo_byte_packer.sv
module rxo_byte_packer
  import rxo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              last_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output rx_word_t          word_o
);
  logic [WORD_W-1:0] acc_q, acc_nx;
  logic [BV_W-1:0]   cnt_q, cnt_nx;
  logic [WORD_W-1:0] lanes;

  assign acc_nx = shift_in(acc_q, byte_i);
  assign cnt_nx = cnt_q + BV_W'(1);
  assign done_o = accept_i && word_closes(cnt_nx, last_i);

  // keep only the lanes that hold gathered bytes
  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    assign lanes[i*BYTE_W +: BYTE_W] =
      (BV_W'(i) < cnt_nx) ? acc_nx[i*BYTE_W +: BYTE_W] : '0;
  end

  assign word_o.data   = lanes;
  assign word_o.nvalid = cnt_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (accept_i) begin
      if (done_o) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_nx;
        cnt_q <= cnt_nx;
      end
    end
  end

  // R4
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < BV_W'(WORD_BYTES));

  // R5
  done_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (word_o.nvalid != '0 && word_o.nvalid <= BV_W'(WORD_BYTES)));
endmodule

// File: rtl/rxo_push_gate.sv
module rxo_push_gate
  import rxo_pkg::*;
#(
  parameter int LVL_W      = 6,
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  rx_word_t          word_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic              push_o,
  output logic [WORD_W-1:0] data_o,
  output logic [BV_W-1:0]   bv_o,
  output logic              ovf_o
);
  logic full;
  assign full = fifo_is_full(int'(level_i), FIFO_DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_o <= 1'b0;
      ovf_o  <= 1'b0;
      data_o <= '0;
      bv_o   <= '0;
    end else begin
      push_o <= done_i && !full;
      ovf_o  <= done_i && full;
      if (done_i && !full) begin
        data_o <= word_i.data;
        bv_o   <= word_i.nvalid;
      end
    end
  end

  // R7
  push_xor_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_o, ovf_o}));

  // R7
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (int'($past(level_i)) < FIFO_DEPTH));

  // R10
  bv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_i && !full) |=> $stable(bv_o));
endmodule

// File: rtl/rxo_request_ctrl.sv
module rxo_request_ctrl
  import rxo_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LVL_W      = 6,
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic [LVL_W-1:0]  fifo_level_i,
  output logic              shift_run_o,
  output logic [CNT_W-1:0]  remaining_o,
  output logic              fifo_push_o,
  output logic [WORD_W-1:0] fifo_data_o,
  output logic [BV_W-1:0]   rx_bv_o,
  output logic              rx_ovf_o
);
  logic     byte_take;
  logic     byte_last;
  logic     word_done;
  rx_word_t word;

  rxo_req_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .wr_i(req_wr_i), .wr_count_i(req_count_i),
    .byte_i(byte_valid_i),
    .remaining_o(remaining_o), .accept_o(byte_take),
    .last_o(byte_last), .run_o(shift_run_o)
  );

  rxo_byte_packer u_pack (
    .clk(clk), .rst_n(rst_n),
    .accept_i(byte_take), .last_i(byte_last), .byte_i(byte_data_i),
    .done_o(word_done), .word_o(word)
  );

  rxo_push_gate #(.LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .done_i(word_done), .word_i(word), .level_i(fifo_level_i),
    .push_o(fifo_push_o), .data_o(fifo_data_o),
    .bv_o(rx_bv_o), .ovf_o(rx_ovf_o)
  );

  // R6
  run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last |=> !shift_run_o);

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr_i && req_count_i != '0) |-> !word_done);
endmodule

// File: tb/tb_rxo_request_ctrl.sv
module tb_rxo_request_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_count = '0;
  logic        bvld = 1'b0;
  logic [7:0]  bdat = '0;
  logic [5:0]  lvl = '0;
  logic        run, push, ovf;
  logic [15:0] rem;
  logic [31:0] data;
  logic [2:0]  bv;

  int compared = 0;
  int mismatched = 0;

  // model state
  int unsigned rem_m = 0, cnt_m = 0, bv_m = 0;
  logic [7:0]  pend [4];

  always #2 clk = ~clk;

  rxo_request_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_wr_i(req_wr), .req_count_i(req_count),
    .byte_valid_i(bvld), .byte_data_i(bdat), .fifo_level_i(lvl),
    .shift_run_o(run), .remaining_o(rem), .fifo_push_o(push),
    .fifo_data_o(data), .rx_bv_o(bv), .rx_ovf_o(ovf)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // earliest byte ends up most significant, valid bytes right-aligned
  function automatic logic [31:0] model_word(input int unsigned n);
    logic [31:0] w = '0;
    for (int i = 0; i < int'(n); i++) w = w | (32'(pend[i]) << (8 * (int'(n) - 1 - i)));
    return w;
  endfunction

  task automatic cyc(input logic wr, input logic [15:0] wc, input logic v,
                     input logic [7:0] b, input logic [5:0] l);
    logic        e_push = 1'b0, e_ovf = 1'b0;
    logic [31:0] e_data = '0;
    @(negedge clk);
    req_wr = wr; req_count = wc; bvld = v; bdat = b; lvl = l;
    if (wr && wc != 0) rem_m = wc;
    else if (v && rem_m != 0) begin
      pend[cnt_m] = b; cnt_m++; rem_m--;
      if (cnt_m == 4 || rem_m == 0) begin
        if (l >= 6'd32) e_ovf = 1'b1;
        else begin e_push = 1'b1; e_data = model_word(cnt_m); bv_m = cnt_m; end
        cnt_m = 0;
      end
    end
    @(posedge clk); #1;
    check("R7", "push", 32'(push), 32'(e_push));
    check("R7", "overflow", 32'(ovf), 32'(e_ovf));
    if (e_push) begin
      if (bv_m == 4) check("R4", "full word", data, e_data);
      else           check("R5", "partial word", data, e_data);
    end
    check("R10", "valid bytes", 32'(bv), 32'(bv_m));
    check("R3", "remaining", 32'(rem), 32'(rem_m));
    check("R6", "run", 32'(run), 32'(rem_m != 0));
    @(negedge clk);
    req_wr = 0; bvld = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "remaining", 32'(rem), 0);
    check("R1", "run", 32'(run), 0);
    check("R1", "push", 32'(push), 0);
    check("R1", "ovf", 32'(ovf), 0);
    check("R1", "bv", 32'(bv), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 zero write ignored
    cyc(1, 16'd0, 0, 8'h00, 6'd0);
    check("R2", "zero write remaining", 32'(rem), 0);
    // R3 stray byte while idle ignored
    cyc(0, 16'd0, 1, 8'hAA, 6'd0);
    check("R3", "stray byte no push", 32'(push), 0);
    // R2 load
    cyc(1, 16'd6, 0, 8'h00, 6'd0);
    check("R2", "load", 32'(rem), 6);
    check("R2", "run high", 32'(run), 1);
    cyc(0, 16'd0, 1, 8'h11, 6'd0);
    cyc(0, 16'd0, 1, 8'h22, 6'd0);
    // R9 same-cycle write wins, byte dropped
    cyc(1, 16'd3, 1, 8'hEE, 6'd0);
    check("R9", "write wins", 32'(rem), 3);
    // R8 replaced count, gathered bytes continue
    cyc(0, 16'd0, 1, 8'h33, 6'd0);
    cyc(0, 16'd0, 1, 8'h44, 6'd0);
    check("R8", "continued word", data, 32'h11223344);
    cyc(0, 16'd0, 1, 8'h55, 6'd0);
    check("R5", "single byte tail", data, 32'h00000055);
    check("R6", "run low", 32'(run), 0);
    // R7 overflow drops word, bv unchanged
    cyc(1, 16'd2, 0, 8'h00, 6'd0);
    cyc(0, 16'd0, 1, 8'h66, 6'd32);
    cyc(0, 16'd0, 1, 8'h77, 6'd32);
    check("R7", "ovf pulse", 32'(ovf), 1);
    check("R10", "bv kept", 32'(bv), 1);

    // random requests
    for (int r = 0; r < 60; r++) begin
      int unsigned len = 1 + ($urandom % 11);
      cyc(1, 16'(len), 0, 8'h00, 6'd0);
      while (rem_m != 0) begin
        logic [5:0] l = (($urandom % 8) == 0) ? 6'd32 : 6'($urandom % 32);
        if (($urandom % 4) == 0) cyc(0, 16'd0, 0, 8'h00, l);
        else cyc(0, 16'd0, 1, 8'($urandom), l);
      end
      if (($urandom % 5) == 0) cyc(0, 16'd0, 1, 8'($urandom), 6'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule